// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block pairs an up-counting timer with a compare register of the same width. It watches the two values in every cycle. When they become equal, a four-bit mode selects what happens. The compare output latch can toggle, be driven high, or be driven low. The interrupt flag can be raised with no pin action. An event trigger can be fired, which restarts the timer from zero and requests an ADC conversion.

In event mode the compare register acts as the timer's period. The timer advances only on cycles where the `tick` enable is high. The restart from the event is not applied at once: it waits for the next tick after the match. Software can cancel it by rewriting the compare register before that tick.

Software reaches the block through a byte-wide write port. Select 0 holds the mode. Select 1 and select 2 hold the low and high bytes of the compare register.

Top module: `tmr_cmp_unit`

## Requirements
- R1: A match is the timer equal to the compare register in all 16 bits. Match actions fire once, in the cycle the equality first becomes true, so a timer that holds at the compare value does not repeat the action.
- R2: In each of the modes 0010, 1000, 1001, 1010 and 1011, a match edge sets `irq_flag` in the next cycle. `flag_clr` clears the flag, and a set in the same cycle wins over the clear. Every other mode code gives no flag and no pin action.
- R3: In mode 0010 a match edge inverts `cmp_out`.
- R4: Writing mode 1000 drives `cmp_out` low, and a later match edge drives it high. Writing mode 1001 drives `cmp_out` high, and a later match edge drives it low.
- R5: In mode 1010 a match edge only sets the flag: `cmp_out` keeps its level and `cmp_oe` stays low.
- R6: In mode 1011, `adc_start` is high combinationally in the cycle the match edge is seen, provided `adc_en` is high. `cmp_oe` is low in this mode.
- R7: After an event-mode match edge, the first later tick loads the timer with zero instead of incrementing it. A tick in the match-edge cycle itself is an ordinary increment.
- R8: A tick at 0xFFFF wraps the timer to zero and sets `ovf_flag`, and `ovf_clr` clears it (a set in the same cycle wins). A restart caused by the event trigger never sets `ovf_flag`.
- R9: A write to either compare byte cancels a pending event restart. This holds from the match-edge cycle up to and including the tick that would apply the restart, and that tick then increments normally.
- R10: Writing mode 0000 forces `cmp_out` low.
- R11: The write select is decoded as follows: 0 writes the mode from `wr_data[3:0]`, 1 writes the compare low byte, 2 writes the compare high byte, and 3 is ignored. `cmp_oe` is high exactly in modes 0010, 1000 and 1001. A mode write in the same cycle as a match edge works in two steps: the edge acts under the old mode, and the new mode's entry level then decides the latch.
- R12: After reset, the timer, the compare register, the mode, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: mode, compare low, compare high |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Timer advance enable |
| adc_en | input | 1 | ADC enabled; gates the conversion request |
| flag_clr | input | 1 | Clears the compare interrupt flag |
| ovf_clr | input | 1 | Clears the timer overflow flag |
| tmr_val | output | 16 | Timer value |
| cmp_out | output | 1 | Compare output latch |
| cmp_oe | output | 1 | High when the mode controls the pin |
| irq_flag | output | 1 | Compare interrupt flag |
| ovf_flag | output | 1 | Timer overflow flag |
| adc_start | output | 1 | ADC conversion request pulse |

## Verification
Two actions can land in the same cycle: a rewrite of the compare register and the tick that would apply a pending event restart. The bench provokes this on purpose. It arms the restart with a match, then issues the compare write and the tick together, and expects the timer to increment rather than clear. Random stimulus also makes writes, ticks and match edges coincide. A cycle model built from the requirements judges every cycle, including the case where a mode write meets a match edge.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    localparam logic [3:0] MD_OFF  = 4'b0000;
    localparam logic [3:0] MD_TOG  = 4'b0010;
    localparam logic [3:0] MD_HI   = 4'b1000;
    localparam logic [3:0] MD_LO   = 4'b1001;
    localparam logic [3:0] MD_FLAG = 4'b1010;
    localparam logic [3:0] MD_EVT  = 4'b1011;

    // Modes that react to a match at all
    function automatic logic md_active(input logic [3:0] m);
        return (m == MD_TOG) || (m == MD_HI) || (m == MD_LO) ||
               (m == MD_FLAG) || (m == MD_EVT);
    endfunction

    // Modes that own the output pin
    function automatic logic md_drives(input logic [3:0] m);
        return (m == MD_TOG) || (m == MD_HI) || (m == MD_LO);
    endfunction

endpackage

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs #(
    parameter int TMR_W  = 16,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [3:0]        mode_q,
    output logic [TMR_W-1:0]  cmp_val,
    output logic              cmp_wr,
    output logic              mode_wr,
    output logic [3:0]        mode_new
);
    localparam int NBYTES = TMR_W / DATA_W;

    typedef struct packed {
        logic [3:0]       mode;
        logic [TMR_W-1:0] cmp;
    } regs_s;

    regs_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBYTES; b++) begin
            if (wr_en && wr_sel == SEL_W'(b + 1))
                st_d.cmp[b*DATA_W +: DATA_W] = wr_data;
        end
        if (wr_en && wr_sel == '0)
            st_d.mode = wr_data[3:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_q   = st_q.mode;
    assign cmp_val  = st_q.cmp;
    assign cmp_wr   = wr_en && (wr_sel != '0) && (wr_sel <= SEL_W'(NBYTES));
    assign mode_wr  = wr_en && (wr_sel == '0);
    assign mode_new = wr_data[3:0];

    AST_SEL3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(NBYTES + 1)) |=> $stable(cmp_val) && $stable(mode_q)); // R11

endmodule

// File: rtl/tmr_cmp_timer.sv
module tmr_cmp_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmp_wr,
    input  logic             evt_fire,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] tmr_val,
    output logic             ovf_flag,
    output logic             rst_pend
);
    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic             ovf;
        logic             pend;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ovf_clr) st_d.ovf = 1'b0;
        if (tick) begin
            if (st_q.pend && !cmp_wr) begin
                st_d.tmr = '0;
            end else begin
                st_d.tmr = st_q.tmr + TMR_W'(1);
                if (st_q.tmr == '1) st_d.ovf = 1'b1;
            end
        end
        if (cmp_wr)        st_d.pend = 1'b0;
        else if (evt_fire) st_d.pend = 1'b1;
        else if (tick)     st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_val  = st_q.tmr;
    assign ovf_flag = st_q.ovf;
    assign rst_pend = st_q.pend;

    AST_PEND_CLEARS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pend && tick && !cmp_wr) |=> (tmr_val == '0)); // R7

    AST_EVT_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pend && tick && !cmp_wr && !ovf_flag) |=> !ovf_flag); // R8

    AST_WRITE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !rst_pend); // R9

    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rst_pend && tmr_val == '1) |=> ovf_flag); // R8

endmodule

// File: rtl/tmr_cmp_action.sv
module tmr_cmp_action
    import tmr_cmp_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic [TMR_W-1:0] cmp_val,
    input  logic [3:0]       mode_q,
    input  logic             mode_wr,
    input  logic [3:0]       mode_new,
    input  logic             adc_en,
    input  logic             flag_clr,
    output logic             cmp_out,
    output logic             cmp_oe,
    output logic             irq_flag,
    output logic             adc_start,
    output logic             evt_fire
);
    typedef struct packed {
        logic out;
        logic irq;
        logic prev;
    } act_s;

    act_s st_d, st_q;
    logic match, rise;

    assign match = (tmr_val == cmp_val);
    assign rise  = match && !st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = match;
        if (flag_clr) st_d.irq = 1'b0;
        if (rise && md_active(mode_q)) st_d.irq = 1'b1;
        if (rise) begin
            case (mode_q)
                MD_TOG:  st_d.out = !st_q.out;
                MD_HI:   st_d.out = 1'b1;
                MD_LO:   st_d.out = 1'b0;
                default: ;
            endcase
        end
        if (mode_wr) begin
            case (mode_new)
                MD_OFF:  st_d.out = 1'b0;
                MD_HI:   st_d.out = 1'b0;
                MD_LO:   st_d.out = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_out   = st_q.out;
    assign irq_flag  = st_q.irq;
    assign cmp_oe    = md_drives(mode_q);
    assign evt_fire  = rise && (mode_q == MD_EVT);
    assign adc_start = evt_fire && adc_en;

    AST_HOLD_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.prev && !mode_wr) |=> $stable(cmp_out)); // R1

    AST_IRQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && md_active(mode_q)) |=> irq_flag); // R2

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && mode_q == MD_TOG && !mode_wr) |=> (cmp_out != $past(cmp_out))); // R3

    AST_LO_ENTRY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_new == MD_LO) |=> cmp_out); // R4

    AST_FLAG_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_FLAG && !mode_wr) |=> $stable(cmp_out)); // R5

    AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_new == MD_OFF) |=> !cmp_out); // R10

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
    parameter int TMR_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [$clog2(TMR_W/DATA_W+2)-1:0] wr_sel,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             tick,
    input  logic                             adc_en,
    input  logic                             flag_clr,
    input  logic                             ovf_clr,
    output logic [TMR_W-1:0]                 tmr_val,
    output logic                             cmp_out,
    output logic                             cmp_oe,
    output logic                             irq_flag,
    output logic                             ovf_flag,
    output logic                             adc_start
);
    localparam int SEL_W = $clog2(TMR_W / DATA_W + 2);

    logic [3:0]       mode_q, mode_new;
    logic [TMR_W-1:0] cmp_val;
    logic             cmp_wr, mode_wr, evt_fire, rst_pend;

    tmr_cmp_regs #(.TMR_W(TMR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mode_q(mode_q), .cmp_val(cmp_val), .cmp_wr(cmp_wr),
        .mode_wr(mode_wr), .mode_new(mode_new)
    );

    tmr_cmp_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_wr(cmp_wr),
        .evt_fire(evt_fire), .ovf_clr(ovf_clr),
        .tmr_val(tmr_val), .ovf_flag(ovf_flag), .rst_pend(rst_pend)
    );

    tmr_cmp_action #(.TMR_W(TMR_W)) u_action (
        .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .cmp_val(cmp_val),
        .mode_q(mode_q), .mode_wr(mode_wr), .mode_new(mode_new),
        .adc_en(adc_en), .flag_clr(flag_clr),
        .cmp_out(cmp_out), .cmp_oe(cmp_oe), .irq_flag(irq_flag),
        .adc_start(adc_start), .evt_fire(evt_fire)
    );

    AST_TRIGGER_ARMS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && !cmp_wr) |=> rst_pend); // R6

endmodule

// File: tb/tmr_cmp_unit_bench.sv
module tmr_cmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        tick = 1'b0, adc_en = 1'b0, flag_clr = 1'b0, ovf_clr = 1'b0;
    logic [15:0] tmr_val;
    logic        cmp_out, cmp_oe, irq_flag, ovf_flag, adc_start;

    int errors = 0;
    int checks = 0;
    bit aen = 1'b0;

    // reference model state
    logic [15:0] m_tmr, m_cmp;
    logic [3:0]  m_mode;
    bit m_out, m_irq, m_ovf, m_pend, m_prev;

    always #2 clk = ~clk;

    tmr_cmp_unit u_tmr_cmp_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick(tick), .adc_en(adc_en), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
        .tmr_val(tmr_val), .cmp_out(cmp_out), .cmp_oe(cmp_oe), .irq_flag(irq_flag),
        .ovf_flag(ovf_flag), .adc_start(adc_start)
    );

    function automatic bit exp_active(logic [3:0] m);
        return m == 4'b0010 || m == 4'b1000 || m == 4'b1001 || m == 4'b1010 || m == 4'b1011;
    endfunction

    function automatic bit exp_drives(logic [3:0] m);
        return m == 4'b0010 || m == 4'b1000 || m == 4'b1001;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0; tick = 1'b0; flag_clr = 1'b0; ovf_clr = 1'b0;
        m_tmr = '0; m_cmp = '0; m_mode = '0;
        m_out = 0; m_irq = 0; m_ovf = 0; m_pend = 0; m_prev = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive at the falling edge, check, advance the model.
    task automatic step(string tag, bit we, logic [1:0] sel, logic [7:0] dat,
                        bit tk, bit fclr, bit oclr);
        bit eq, rise, cw, mw;
        wr_en = we; wr_sel = sel; wr_data = dat; tick = tk;
        flag_clr = fclr; ovf_clr = oclr; adc_en = aen;
        #1;
        eq   = (m_tmr == m_cmp);
        rise = eq && !m_prev;
        chk(tag, "tmr_val R7", int'(tmr_val), int'(m_tmr));
        chk(tag, "cmp_out R3", int'(cmp_out), int'(m_out));
        chk(tag, "cmp_oe R11", int'(cmp_oe), int'(exp_drives(m_mode)));
        chk(tag, "irq_flag R2", int'(irq_flag), int'(m_irq));
        chk(tag, "ovf_flag R8", int'(ovf_flag), int'(m_ovf));
        chk(tag, "adc_start R6", int'(adc_start), int'(rise && m_mode == 4'b1011 && aen));
        cw = we && (sel == 2'd1 || sel == 2'd2);
        mw = we && sel == 2'd0;
        if (rise) begin
            if (m_mode == 4'b0010) m_out = !m_out;
            else if (m_mode == 4'b1000) m_out = 1;
            else if (m_mode == 4'b1001) m_out = 0;
        end
        if (mw) begin
            if (dat[3:0] == 4'b0000 || dat[3:0] == 4'b1000) m_out = 0;
            else if (dat[3:0] == 4'b1001) m_out = 1;
        end
        if (fclr) m_irq = 0;
        if (rise && exp_active(m_mode)) m_irq = 1;
        if (oclr) m_ovf = 0;
        if (tk) begin
            if (m_pend && !cw) m_tmr = '0;
            else begin
                if (m_tmr == 16'hFFFF) m_ovf = 1;
                m_tmr = m_tmr + 16'd1;
            end
        end
        if (cw) m_pend = 0;
        else if (rise && m_mode == 4'b1011) m_pend = 1;
        else if (tk) m_pend = 0;
        m_prev = eq;
        if (we && sel == 2'd1) m_cmp[7:0] = dat;
        if (we && sel == 2'd2) m_cmp[15:8] = dat;
        if (mw) m_mode = dat[3:0];
        @(negedge clk);
    endtask

    task automatic wr(string tag, logic [1:0] sel, logic [7:0] dat);
        step(tag, 1, sel, dat, 0, 0, 0);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic ticks(string tag, int n);
        for (int i = 0; i < n; i++) begin
            step(tag, 0, 0, 0, 1, 0, 0);
            step(tag, 0, 0, 0, 0, 0, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        @(negedge clk);
        do_reset();
        idle("R12", 2);
        chk("R12", "tmr_val", int'(tmr_val), 0);

        // mode entry levels and forced-low clear
        wr("R4", 2'd0, 8'h09);
        chk("R4", "cmp_out after 1001", int'(cmp_out), 1);
        wr("R10", 2'd0, 8'h00);
        chk("R10", "cmp_out after 0000", int'(cmp_out), 0);
        wr("R4", 2'd0, 8'h08);
        wr("R4", 2'd1, 8'h03);
        ticks("R4", 3);
        chk("R4", "cmp_out set on match", int'(cmp_out), 1);

        // toggle, then hold at compare value: one toggle only
        do_reset();
        wr("R3", 2'd1, 8'h05);
        wr("R3", 2'd0, 8'h02);
        ticks("R3", 5);
        idle("R1", 6);
        chk("R1", "single toggle while held", int'(cmp_out), 1);
        step("R2", 0, 0, 0, 0, 1, 0);
        chk("R2", "irq cleared", int'(irq_flag), 0);

        // flag-only mode
        do_reset();
        wr("R5", 2'd1, 8'h02);
        wr("R5", 2'd0, 8'h0A);
        ticks("R5", 2);
        chk("R5", "irq set", int'(irq_flag), 1);
        chk("R5", "no pin drive", int'(cmp_oe), 0);
        wr("R11", 2'd3, 8'h55);

        // event trigger as period register
        do_reset();
        aen = 1;
        wr("R6", 2'd1, 8'h03);
        wr("R6", 2'd0, 8'h0B);
        ticks("R7", 12);
        step("R7", 0, 0, 0, 1, 0, 0);
        step("R7", 0, 0, 0, 1, 0, 0);
        ticks("R8", 6);
        chk("R8", "no overflow from restart", int'(ovf_flag), 0);

        // cancel: compare rewrite in the same cycle as the restart tick
        do_reset();
        wr("R9", 2'd1, 8'h04);
        wr("R9", 2'd0, 8'h0B);
        ticks("R9", 4);
        idle("R9", 1);
        step("R9", 1, 2'd1, 8'h09, 1, 0, 0);
        chk("R9", "tmr incremented not cleared", int'(tmr_val), 5);
        aen = 0;

        // mode write colliding with a match edge
        do_reset();
        wr("R11", 2'd1, 8'h01);
        wr("R11", 2'd0, 8'h02);
        step("R11", 0, 0, 0, 1, 0, 0);
        step("R11", 1, 2'd0, 8'h09, 0, 0, 0);
        chk("R11", "entry level wins", int'(cmp_out), 1);

        // full wrap
        do_reset();
        for (int i = 0; i < 65536; i++) step("R8", 0, 0, 0, 1, 0, 0);
        chk("R8", "wrap overflow", int'(ovf_flag), 1);
        step("R8", 0, 0, 0, 0, 0, 1);
        chk("R8", "ovf cleared", int'(ovf_flag), 0);

        // constrained random
        for (int n = 0; n < 6; n++) begin
            do_reset();
            for (int i = 0; i < 500; i++) begin
                bit we; logic [1:0] sel; logic [7:0] dat; int pick;
                we  = ($urandom % 5) == 0;
                sel = 2'($urandom % 4);
                pick = $urandom % 7;
                if (sel == 2'd0)
                    dat = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h02 : (pick == 2) ? 8'h08 :
                          (pick == 3) ? 8'h09 : (pick == 4) ? 8'h0A : (pick == 5) ? 8'h0B :
                          8'($urandom);
                else if (sel == 2'd2) dat = 8'h00;
                else dat = 8'($urandom % 16);
                if (($urandom % 16) == 0) aen = !aen;
                step("RND", we, sel, dat, ($urandom % 2) == 0,
                     ($urandom % 10) == 0, ($urandom % 10) == 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule